// File: doc/BRIEF.md
# Soft Reset and Clock Enable Sequencer

This block is the control front end of a subsystem. It owns the subsystem's soft reset and the enable of its gated clock, and it keeps running totals of the bytes the subsystem sends and receives. Software works with it through a small word-wide register port.

Software sets a request bit to hold the subsystem in reset. After a fixed number of cycles a done bit reports that the reset has completed. Software sets an enable bit to turn on the gated clock, and after a fixed number of cycles a status bit confirms that the clock is running. The usual bring-up order is:

1. Request reset.
2. Enable the clock and wait for its status bit.
3. Release the reset request.

The block keeps two byte totals, one for transmit and one for receive. Each is two words wide and grows by the amount presented on its strobe. Both totals are forced to zero while the reset request is set. Each total is read as a low word and a high word. Reading the low word captures the high word at the same instant, so that a later read of the high word matches it.

Top module: `subsys_ctl_seq`

## Requirements
- R1: After reset the following hold: every register address reads zero, `gclk_en` is 0 and `sub_rst_n` is 1.
- R2: Register map, by address:
  - 0: control. Bit 0 is the clock enable and bit 1 is the reset request; both are read/write.
  - 1: status. Bit 0 is clock running and bit 1 is reset done; both are read-only.
  - 2: transmit total, low word.
  - 3: transmit total, high word.
  - 4: receive total, low word.
  - 5: receive total, high word.
  - 6 and 7: read as zero.
  - A write to any address other than 0 has no effect.
- R3: Writing 1 to the reset request drives `sub_rst_n` low in the same cycle the control register updates. The reset-done bit reads 1 starting exactly RST_CYCLES clock edges after the write edge, and reads 0 before that.
- R4: After the reset request is cleared, `sub_rst_n` returns to 1 at once. The reset-done bit still reads 1 in the cycle right after the clearing write and reads 0 from the next cycle.
- R5: Writing 1 to the clock enable makes `gclk_en` 1 at once. The clock-running bit reads 1 starting exactly CLK_CYCLES edges after the write edge.
- R6: After the clock enable is cleared, `gclk_en` returns to 0 at once. The clock-running bit still reads 1 in the cycle right after the clearing write and reads 0 from the next cycle.
- R7: On each cycle its strobe is high, a byte total adds its increment input, modulo 2^(2*WORD_W). The transmit and receive totals are independent of each other.
- R8: A low-word read captures the high word of the same total at that cycle. A later high-word read returns the captured value, even if the total has changed since.
- R9: While the reset request is set, both totals are held at zero and strobes are ignored. The totals read zero starting on the second cycle after the request is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (capture side effect on low-word reads) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for `reg_addr`, combinational |
| tx_strobe | input | 1 | Transmit byte increment valid |
| tx_bytes | input | INC_W | Transmit byte increment |
| rx_strobe | input | 1 | Receive byte increment valid |
| rx_bytes | input | INC_W | Receive byte increment |
| gclk_en | output | 1 | Enable to the external clock gating cell |
| sub_rst_n | output | 1 | Active-low soft reset to the subsystem |

## Verification
The assertions check several things on every cycle:
- Each done or running flag agrees with an independent count of the cycles its control bit has been held.
- Both flags drop one cycle after their control bit clears.
- The totals stay at zero under a reset request.
- A total never moves without its strobe.

Some behaviour only the bench scenarios can show:
- The exact cycle at which each flag appears through the register port.
- The arithmetic of the totals across a carry into the high word.
- The consistency of a captured high word after further traffic.
- That unmapped addresses, and writes outside the control register, have no effect.

// File: rtl/ssc_pkg.sv
// Package: shared register addresses for the soft reset / clock sequencer.
// Assumes a 3-bit word address; unlisted addresses read as zero.
package ssc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_TX_LO = 3'd2,
        A_TX_HI = 3'd3,
        A_RX_LO = 3'd4,
        A_RX_HI = 3'd5
    } reg_sel_e;

    localparam int B_CLK = 0;  // clock enable / clock running
    localparam int B_RST = 1;  // reset request / reset done
endpackage

// File: rtl/ssc_delay.sv
// Module: level-qualified delay timer.
// Raises done once level has been held for DELAY clock edges; done drops on
// the first edge that sees level low. Assumes DELAY >= 1.
module ssc_delay #(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Count edges with level held; saturate once done is raised.
    always_ff @(posedge clk) begin
        if (!rst_n || !level) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DELAY - 1)) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssc_byte_acc.sv
// Module: wrapping byte total.
// Adds inc on each strobe, modulo 2^CNT_W. A high clr holds the total at
// zero and overrides the strobe.
module ssc_byte_acc #(
    parameter int CNT_W = 64,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] total
);
    // Accumulate increments, or hold at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total <= '0;
        end else if (strobe) begin
            total <= total + CNT_W'(inc);
        end
    end
endmodule

// File: rtl/ssc_regs.sv
// Module: register file and read path.
// Holds the two control bits, decodes the read mux and keeps a capture of
// each total's high word, taken on a low-word read. Read data is
// combinational on reg_addr. Assumes single-cycle rd/wr strobes.
module ssc_regs
    import ssc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    input  logic                clk_on,
    input  logic                rst_done,
    input  logic [2*WORD_W-1:0] tx_total,
    input  logic [2*WORD_W-1:0] rx_total,
    output logic                ctrl_clk_en,
    output logic                ctrl_rst_req
);
    logic [WORD_W-1:0] tx_hi_cap, rx_hi_cap;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[WORD_W-1:2];

    // Control register: only address 0 is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_clk_en  <= 1'b0;
            ctrl_rst_req <= 1'b0;
        end else if (wr && addr == A_CTRL) begin
            ctrl_clk_en  <= wdata[B_CLK];
            ctrl_rst_req <= wdata[B_RST];
        end
    end

    // High-word capture on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hi_cap <= '0;
            rx_hi_cap <= '0;
        end else if (rd) begin
            if (addr == A_TX_LO) tx_hi_cap <= tx_total[2*WORD_W-1:WORD_W];
            if (addr == A_RX_LO) rx_hi_cap <= rx_total[2*WORD_W-1:WORD_W];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_CLK] = ctrl_clk_en;
                rdata[B_RST] = ctrl_rst_req;
            end
            A_STAT: begin
                rdata[B_CLK] = clk_on;
                rdata[B_RST] = rst_done;
            end
            A_TX_LO: rdata = tx_total[WORD_W-1:0];
            A_TX_HI: rdata = tx_hi_cap;
            A_RX_LO: rdata = rx_total[WORD_W-1:0];
            A_RX_HI: rdata = rx_hi_cap;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/subsys_ctl_seq.sv
// Module: soft reset and clock enable sequencer (top).
// Drives the subsystem's soft reset and clock-gate enable from control
// bits. Reports reset completion and clock-on after parameterised delays.
// Keeps transmit and receive byte totals of 2*WORD_W bits each.
// Assumes: the gating cell and the datapath are outside; RST_CYCLES >= 1
// and CLK_CYCLES >= 1.
module subsys_ctl_seq #(
    parameter int WORD_W     = 32,
    parameter int INC_W      = 16,
    parameter int RST_CYCLES = 16,
    parameter int CLK_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_strobe,
    input  logic [INC_W-1:0]  tx_bytes,
    input  logic              rx_strobe,
    input  logic [INC_W-1:0]  rx_bytes,
    output logic              gclk_en,
    output logic              sub_rst_n
);
    localparam int CNT_W = 2 * WORD_W;
    localparam int NCH   = 2;  // channel 0 transmit, channel 1 receive

    logic             ctrl_clk_en, ctrl_rst_req;
    logic             clk_on, rst_done;
    logic [CNT_W-1:0] totals [NCH];
    logic [NCH-1:0]   strobes;
    logic [INC_W-1:0] incs   [NCH];
    logic [CNT_W-1:0] tx_cnt, rx_cnt;

    assign gclk_en   = ctrl_clk_en;
    assign sub_rst_n = ~ctrl_rst_req;
    assign strobes   = {rx_strobe, tx_strobe};
    assign incs[0]   = tx_bytes;
    assign incs[1]   = rx_bytes;
    assign tx_cnt    = totals[0];
    assign rx_cnt    = totals[1];

    ssc_regs #(.WORD_W(WORD_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .rd           (reg_rd),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .clk_on       (clk_on),
        .rst_done     (rst_done),
        .tx_total     (tx_cnt),
        .rx_total     (rx_cnt),
        .ctrl_clk_en  (ctrl_clk_en),
        .ctrl_rst_req (ctrl_rst_req)
    );

    ssc_delay #(.DELAY(RST_CYCLES)) u_rst_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctrl_rst_req),
        .done  (rst_done)
    );

    ssc_delay #(.DELAY(CLK_CYCLES)) u_clk_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctrl_clk_en),
        .done  (clk_on)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_acc
        ssc_byte_acc #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ctrl_rst_req),
            .strobe (strobes[ch]),
            .inc    (incs[ch]),
            .total  (totals[ch])
        );
    end
endmodule

// File: rtl/ssc_checker.sv
// Module: cycle-by-cycle checker for subsys_ctl_seq, attached with bind.
// Keeps its own hold counters for the two control bits and compares them
// with the reported flags.
module ssc_checker #(
    parameter int RST_CYCLES = 16,
    parameter int CLK_CYCLES = 8,
    parameter int CNT_W      = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_clk_en,
    input logic             ctrl_rst_req,
    input logic             clk_on,
    input logic             rst_done,
    input logic             tx_strobe,
    input logic             rx_strobe,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt
);
    logic [31:0] rwin, cwin;

    // Count edges for which each control bit has been held; saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rwin <= '0;
            cwin <= '0;
        end else begin
            rwin <= !ctrl_rst_req ? '0 : (rwin == 32'hFFFF_FFFF ? rwin : rwin + 1);
            cwin <= !ctrl_clk_en  ? '0 : (cwin == 32'hFFFF_FFFF ? cwin : cwin + 1);
        end
    end

    p_done_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done == (rwin >= 32'(RST_CYCLES)));

    p_done_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rst_req |=> !rst_done);

    p_clk_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_on == (cwin >= 32'(CLK_CYCLES)));

    p_clk_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_clk_en |=> !clk_on);

    p_tx_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rst_req && !tx_strobe) |=> $stable(tx_cnt));

    p_rx_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rst_req && !rx_strobe) |=> $stable(rx_cnt));

    p_held_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_req |=> (tx_cnt == '0 && rx_cnt == '0));
endmodule

bind subsys_ctl_seq ssc_checker #(
    .RST_CYCLES (RST_CYCLES),
    .CLK_CYCLES (CLK_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_clk_en  (ctrl_clk_en),
    .ctrl_rst_req (ctrl_rst_req),
    .clk_on       (clk_on),
    .rst_done     (rst_done),
    .tx_strobe    (tx_strobe),
    .rx_strobe    (rx_strobe),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt)
);

// File: tb/tb_subsys_ctl_seq.sv
// Bench for subsys_ctl_seq in a small configuration: 16-bit words (32-bit
// totals), 8-bit increments, RST_CYCLES=5, CLK_CYCLES=3.
module tb_subsys_ctl_seq;
    localparam int W    = 16;
    localparam int IW   = 8;
    localparam int RSTC = 5;
    localparam int CLKC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          tx_strobe = 1'b0, rx_strobe = 1'b0;
    logic [IW-1:0] tx_bytes = '0, rx_bytes = '0;
    logic          gclk_en, sub_rst_n;

    int          n_tests = 0, n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] tx_sum = '0, rx_sum = '0;
    logic [W-1:0] rv, cap;

    always #2 clk = ~clk;

    subsys_ctl_seq #(.WORD_W(W), .INC_W(IW), .RST_CYCLES(RSTC), .CLK_CYCLES(CLKC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_strobe(tx_strobe), .tx_bytes(tx_bytes),
        .rx_strobe(rx_strobe), .rx_bytes(rx_bytes),
        .gclk_en(gclk_en), .sub_rst_n(sub_rst_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read one register; samples combinational data, then spends one cycle.
    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic push(input bit ts, input logic [IW-1:0] tb_, input bit rs,
                        input logic [IW-1:0] rb);
        tx_strobe = ts; tx_bytes = tb_; rx_strobe = rs; rx_bytes = rb;
        @(posedge clk); @(negedge clk);
        tx_strobe = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic read_total(input bit is_rx, output logic [31:0] v);
        logic [W-1:0] lo, hi;
        rd(is_rx ? 3'd4 : 3'd2, lo);
        rd(is_rx ? 3'd5 : 3'd3, hi);
        v = {hi, lo};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            check("R1", $sformatf("addr %0d after reset", a), 32'(rv), 0);
        end
        check("R1", "gclk_en", 32'(gclk_en), 0);
        check("R1", "sub_rst_n", 32'(sub_rst_n), 1);

        // R5: clock enable and running delay (status bit0)
        wr(3'd0, 16'h0001);
        check("R5", "gclk_en after set", 32'(gclk_en), 1);
        for (int j = 0; j <= CLKC + 1; j++) begin
            rd(3'd1, rv);
            check("R5", $sformatf("clk running j=%0d", j), 32'(rv[0]), 32'(j >= CLKC));
        end

        // R3: reset request and done delay (status bit1)
        wr(3'd0, 16'h0003);
        check("R3", "sub_rst_n low", 32'(sub_rst_n), 0);
        for (int j = 0; j <= RSTC + 1; j++) begin
            rd(3'd1, rv);
            check("R3", $sformatf("done j=%0d", j), 32'(rv[1]), 32'(j >= RSTC));
            check("R3", "clk stays running", 32'(rv[0]), 1);
        end

        // R9: strobes ignored while the request is set
        for (int i = 0; i < 4; i++) push(1'b1, 8'hA5, 1'b1, 8'h5A);
        read_total(1'b0, v); check("R9", "tx held", v, 0);
        read_total(1'b1, v); check("R9", "rx held", v, 0);

        // R4: release the request; done lingers one cycle
        wr(3'd0, 16'h0001);
        check("R4", "sub_rst_n high", 32'(sub_rst_n), 1);
        rd(3'd1, rv); check("R4", "done j=0", 32'(rv[1]), 1);
        rd(3'd1, rv); check("R4", "done j=1", 32'(rv[1]), 0);
        rd(3'd0, rv); check("R2", "ctrl readback", 32'(rv), 1);

        // R7: sweep of increments, tx every cycle, rx every odd cycle
        for (int i = 0; i < 300; i++) begin
            logic [IW-1:0] ti, ri;
            ti = IW'((i * 37 + 11) % 256);
            ri = IW'(255 - (i % 200));
            push(1'b1, ti, i[0], ri);
            tx_sum = tx_sum + 32'(ti);
            if (i[0]) rx_sum = rx_sum + 32'(ri);
        end
        read_total(1'b0, v); check("R7", "tx sweep total", v, tx_sum);
        read_total(1'b1, v); check("R7", "rx sweep total", v, rx_sum);

        // R7: carry into the high word (push tx past 2^16 multiples)
        for (int i = 0; i < 300; i++) push(1'b1, 8'hFF, 1'b0, 8'h00);
        tx_sum = tx_sum + 32'(300 * 255);
        read_total(1'b0, v); check("R7", "tx after carry", v, tx_sum);
        check("R7", "tx high word nonzero", 32'(v[31:16] != 0), 1);

        // R8: capture on low read survives later traffic
        rd(3'd2, rv);
        cap = tx_sum[31:16];
        for (int i = 0; i < 300; i++) push(1'b1, 8'hFF, 1'b0, 8'h00);
        tx_sum = tx_sum + 32'(300 * 255);
        rd(3'd3, rv); check("R8", "captured tx high", 32'(rv), 32'(cap));
        read_total(1'b0, v); check("R8", "fresh tx total", v, tx_sum);
        rd(3'd4, rv);
        cap = rx_sum[31:16];
        for (int i = 0; i < 260; i++) push(1'b0, 8'h00, 1'b1, 8'hFF);
        rx_sum = rx_sum + 32'(260 * 255);
        rd(3'd5, rv); check("R8", "captured rx high", 32'(rv), 32'(cap));
        read_total(1'b1, v); check("R8", "fresh rx total", v, rx_sum);

        // R2: non-control writes ignored, unmapped reads zero
        wr(3'd2, 16'hFFFF); wr(3'd1, 16'hFFFF); wr(3'd6, 16'hFFFF);
        read_total(1'b0, v); check("R2", "tx after stray writes", v, tx_sum);
        rd(3'd1, rv); check("R2", "status after stray write", 32'(rv), 1);
        rd(3'd0, rv); check("R2", "ctrl after stray writes", 32'(rv), 1);
        rd(3'd6, rv); check("R2", "addr 6", 32'(rv), 0);
        rd(3'd7, rv); check("R2", "addr 7", 32'(rv), 0);

        // R9: a new request clears the totals from the second cycle
        wr(3'd0, 16'h0003);
        rd(3'd2, rv); check("R9", "tx lo j=0 old", 32'(rv), 32'(tx_sum[15:0]));
        read_total(1'b0, v); check("R9", "tx cleared", v, 0);
        read_total(1'b1, v); check("R9", "rx cleared", v, 0);

        // R6: clear the clock enable; running lingers one cycle
        wr(3'd0, 16'h0000);
        check("R6", "gclk_en low", 32'(gclk_en), 0);
        rd(3'd1, rv); check("R6", "running j=0", 32'(rv[0]), 1);
        rd(3'd1, rv); check("R6", "running j=1", 32'(rv[0]), 0);
        check("R4", "done cleared too", 32'(rv[1]), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule